// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned binary operands and raises exactly one of three result flags: less-than, equal or greater-than. It is built from identical comparator slices, each covering a fixed number of bits. A slice decides the result on its own whenever its local operand bits differ. When the local bits are equal, the slice passes on the verdict it receives from the next less significant slice.

The top level chains the slices serially from the least significant slice to the most significant one. This gives a wider comparator: by default, two 4-bit slices form an 8-bit comparator. A parameter selects how each slice is built internally. One variant compares the whole slice width at once. The other is a ripple of 1-bit comparator cells, each of which has its own cascade link.

The cascade inputs of the least significant slice are brought out at the top. The top can therefore be chained further. Tying these inputs to the equal code gives a plain comparator. The block has no clock and no state.

Top module: `mag_cmp_chain`

## Requirements
- R1: One slice compares two SLICE_W-bit operands (default 4) as unsigned binary numbers.
- R2: When a slice's operand A is greater than operand B, it drives greater-than high and the other two outputs low, whatever its cascade inputs are.
- R3: When a slice's operand A is less than operand B, it drives less-than high and the other two outputs low, whatever its cascade inputs are.
- R4: When a slice's operands are equal, each output copies its matching cascade input: less-than from less-than, equal from equal, greater-than from greater-than. This holds for every one of the 8 cascade codes.
- R5: For any one-hot cascade input (exactly one of the three high), exactly one output is high.
- R6: In the chained comparator, a difference in a more significant slice decides the result regardless of the lower slices. The top's result equals the unsigned comparison of the full TOTAL_W-bit operands whenever they differ.
- R7: The variant built from 1-bit comparator cells (USE_BIT_CELLS=1) gives the same outputs as the whole-slice variant for every input.
- R8: The top's cascade inputs feed the least significant slice. Driving them to less-than=0, equal=1, greater-than=0 makes equal full-width operands produce equal=1 and the other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | TOTAL_W | Operand A, unsigned |
| b_i | input | TOTAL_W | Operand B, unsigned |
| lt_cas_i | input | 1 | Cascade less-than from a less significant stage |
| eq_cas_i | input | 1 | Cascade equal from a less significant stage |
| gt_cas_i | input | 1 | Cascade greater-than from a less significant stage |
| lt_o | output | 1 | A less than B |
| eq_o | output | 1 | A equal to B |
| gt_o | output | 1 | A greater than B |

## Verification
The bench builds three instances side by side:
- The default two-slice, whole-slice-compare chain.
- The same 8-bit chain built from 1-bit cells.
- A single 4-bit slice (NUM_SLICES=1).

The single slice makes it practical to sweep every operand pair against all eight cascade codes. That sweep covers the pass-through of illegal codes as well as the one-hot ones. The two 8-bit builds receive identical random and corner stimulus. These are operands that differ only in the low slice, only in the high slice, or at the carry boundary between slices. This exposes any disagreement between the slice variants and any wrong priority across the chain.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } cmp_res_t;

  localparam cmp_res_t CMP_EQUAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};
endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell
  import cmp_pkg::*;
(
  input  logic     x_i,
  input  logic     y_i,
  input  cmp_res_t cas_i,
  output cmp_res_t res_o
);
  logic same;

  assign same     = ~(x_i ^ y_i);
  assign res_o.gt = (x_i & ~y_i) | (same & cas_i.gt);
  assign res_o.lt = (~x_i & y_i) | (same & cas_i.lt);
  assign res_o.eq = same & cas_i.eq;

  // a differing bit overrides the lower cascade
  always_comb begin
    if (x_i !== y_i && (x_i == 1'b0 || x_i == 1'b1) && (y_i == 1'b0 || y_i == 1'b1)) begin
      assert_bit_decides_R2: assert (res_o.eq == 1'b0 && res_o.gt == x_i && res_o.lt == y_i)
        else $error("bit cell ignored its own difference");
    end
  end
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
#(
  parameter int W             = 4,
  parameter bit USE_BIT_CELLS = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cmp_res_t     cas_i,
  output cmp_res_t     res_o
);
  generate
    if (USE_BIT_CELLS) begin : g_ripple
      cmp_res_t link [W+1];
      assign link[0] = cas_i;
      for (genvar k = 0; k < W; k++) begin : g_cell
        cmp_bit_cell u_cell (
          .x_i  (a_i[k]),
          .y_i  (b_i[k]),
          .cas_i(link[k]),
          .res_o(link[k+1])
        );
      end
      assign res_o = link[W];
    end else begin : g_whole
      always_comb begin
        if (a_i > b_i)      res_o = '{lt: 1'b0, eq: 1'b0, gt: 1'b1};
        else if (a_i < b_i) res_o = '{lt: 1'b1, eq: 1'b0, gt: 1'b0};
        else                res_o = cas_i;
      end
    end
  endgenerate

  always_comb begin
    if (!$isunknown({a_i, b_i, cas_i})) begin
      if (a_i == b_i) begin
        assert_eq_passthru_R4: assert (res_o == cas_i)
          else $error("equal operands did not pass cascade");
      end
      if ($onehot(cas_i)) begin
        assert_single_out_R5: assert ($onehot(res_o))
          else $error("one-hot cascade gave non one-hot result");
      end
    end
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import cmp_pkg::*;
#(
  parameter int SLICE_W       = 4,
  parameter int NUM_SLICES    = 2,
  parameter bit USE_BIT_CELLS = 1'b0,
  localparam int TOTAL_W      = SLICE_W * NUM_SLICES
) (
  input  logic [TOTAL_W-1:0] a_i,
  input  logic [TOTAL_W-1:0] b_i,
  input  logic               lt_cas_i,
  input  logic               eq_cas_i,
  input  logic               gt_cas_i,
  output logic               lt_o,
  output logic               eq_o,
  output logic               gt_o
);
  cmp_res_t stage [NUM_SLICES+1];

  assign stage[0] = '{lt: lt_cas_i, eq: eq_cas_i, gt: gt_cas_i};

  generate
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      cmp_slice #(
        .W            (SLICE_W),
        .USE_BIT_CELLS(USE_BIT_CELLS)
      ) u_slice (
        .a_i  (a_i[s*SLICE_W +: SLICE_W]),
        .b_i  (b_i[s*SLICE_W +: SLICE_W]),
        .cas_i(stage[s]),
        .res_o(stage[s+1])
      );
    end
  endgenerate

  assign lt_o = stage[NUM_SLICES].lt;
  assign eq_o = stage[NUM_SLICES].eq;
  assign gt_o = stage[NUM_SLICES].gt;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      if (a_i > b_i) begin
        assert_wide_gt_R6: assert (gt_o && !lt_o && !eq_o)
          else $error("chain missed greater-than");
      end
      if (a_i < b_i) begin
        assert_wide_lt_R6: assert (lt_o && !gt_o && !eq_o)
          else $error("chain missed less-than");
      end
      if (a_i == b_i && {lt_cas_i, eq_cas_i, gt_cas_i} == 3'b010) begin
        assert_plain_eq_R8: assert (eq_o && !lt_o && !gt_o)
          else $error("equal operands not reported equal");
      end
    end
  end
endmodule

// File: tb/tb_mag_cmp_chain.sv
module tb_mag_cmp_chain;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] a8 = '0, b8 = '0;
  logic [2:0] cas8 = 3'b010;
  logic [3:0] a4 = '0, b4 = '0;
  logic [2:0] cas4 = 3'b010;
  logic w_lt, w_eq, w_gt, c_lt, c_eq, c_gt, s_lt, s_eq, s_gt;

  mag_cmp_chain dut (
    .a_i(a8), .b_i(b8), .lt_cas_i(cas8[2]), .eq_cas_i(cas8[1]), .gt_cas_i(cas8[0]),
    .lt_o(w_lt), .eq_o(w_eq), .gt_o(w_gt));

  mag_cmp_chain #(.USE_BIT_CELLS(1'b1)) dut_bits (
    .a_i(a8), .b_i(b8), .lt_cas_i(cas8[2]), .eq_cas_i(cas8[1]), .gt_cas_i(cas8[0]),
    .lt_o(c_lt), .eq_o(c_eq), .gt_o(c_gt));

  mag_cmp_chain #(.NUM_SLICES(1)) dut_slice (
    .a_i(a4), .b_i(b4), .lt_cas_i(cas4[2]), .eq_cas_i(cas4[1]), .gt_cas_i(cas4[0]),
    .lt_o(s_lt), .eq_o(s_eq), .gt_o(s_gt));

  typedef struct {
    logic [7:0] a8, b8;
    logic [3:0] a4, b4;
    logic [2:0] exp_w, exp_s;
    string      tag_w, tag_s;
  } item_t;

  item_t q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // result encoding {lt,eq,gt}
  function automatic logic [2:0] model(int a, int b, logic [2:0] cas);
    if (a > b) return 3'b001;
    if (a < b) return 3'b100;
    return cas;
  endfunction

  function automatic string tag_of(int a, int b, logic [2:0] cas, bit wide);
    if (a != b) return wide ? "R6" : (a > b ? "R1/R2" : "R1/R3");
    if (cas == 3'b010) return "R8";
    if ($onehot(cas)) return "R5";
    return "R4";
  endfunction

  task automatic apply(logic [7:0] wa, logic [7:0] wb, logic [2:0] wc,
                       logic [3:0] sa, logic [3:0] sb, logic [2:0] sc);
    item_t it;
    @(posedge clk);
    #1;
    a8 = wa; b8 = wb; cas8 = wc; a4 = sa; b4 = sb; cas4 = sc;
    it.a8 = wa; it.b8 = wb; it.a4 = sa; it.b4 = sb;
    it.exp_w = model(int'(wa), int'(wb), wc);
    it.exp_s = model(int'(sa), int'(sb), sc);
    it.tag_w = tag_of(int'(wa), int'(wb), wc, 1'b1);
    it.tag_s = tag_of(int'(sa), int'(sb), sc, 1'b0);
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_vec++;
      if ({w_lt, w_eq, w_gt} !== it.exp_w) begin
        n_bad++;
        $display("FAIL %s chain a=%h b=%h got %b exp %b", it.tag_w, it.a8, it.b8,
                 {w_lt, w_eq, w_gt}, it.exp_w);
      end
      if ({c_lt, c_eq, c_gt} !== it.exp_w) begin
        n_bad++;
        $display("FAIL R7 (%s) cell chain a=%h b=%h got %b exp %b", it.tag_w, it.a8, it.b8,
                 {c_lt, c_eq, c_gt}, it.exp_w);
      end
      if ({s_lt, s_eq, s_gt} !== it.exp_s) begin
        n_bad++;
        $display("FAIL %s slice a=%h b=%h got %b exp %b", it.tag_s, it.a4, it.b4,
                 {s_lt, s_eq, s_gt}, it.exp_s);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] oh [3] = '{3'b100, 3'b010, 3'b001};
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state: zero operands, equal cascade (R8)
    apply(8'h00, 8'h00, 3'b010, 4'h0, 4'h0, 3'b010);
    // exhaustive slice sweep over all cascade codes (R1..R5)
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          apply(8'(i * 16 + j), 8'(j * 16 + i), 3'(c), 4'(i), 4'(j), 3'(c));
    // chain corners (R6, R8, R4)
    apply(8'hFF, 8'hFF, 3'b010, 4'hF, 4'hF, 3'b010);
    apply(8'hFF, 8'hFE, 3'b100, 4'hF, 4'hE, 3'b100);
    apply(8'h80, 8'h7F, 3'b100, 4'h8, 4'h7, 3'b100);
    apply(8'h0F, 8'h10, 3'b001, 4'h0, 4'h1, 3'b001);
    apply(8'h10, 8'h0F, 3'b100, 4'h1, 4'h0, 3'b100);
    apply(8'h3A, 8'h3B, 3'b001, 4'hA, 4'hB, 3'b001);
    apply(8'h4B, 8'h3B, 3'b100, 4'h4, 4'h3, 3'b100);
    apply(8'h5C, 8'h5C, 3'b000, 4'hC, 4'hC, 3'b000);
    apply(8'h5C, 8'h5C, 3'b111, 4'hC, 4'hC, 3'b111);
    apply(8'h5C, 8'h5C, 3'b001, 4'hC, 4'hC, 3'b001);
    // random (R6, R7)
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] ra, rb;
      logic [2:0] rc;
      ra = 8'($urandom);
      rb = ($urandom % 4 == 0) ? ra : 8'($urandom);
      if ($urandom % 3 == 0) rb[7:4] = ra[7:4];
      rc = ($urandom % 2 == 0) ? 3'b010 : oh[$urandom % 3];
      apply(ra, rb, rc, ra[3:0], rb[3:0], rc);
    end
    @(posedge clk);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule